// File: doc/BRIEF.md
# Prescaled Auto-Reload Interval Timer

This block produces a periodic interrupt pulse. A free-running prescale stage divides the clock by any ratio from 1 to 256 and emits a tick. Each tick steps a 16-bit down counter. When the counter steps from one to zero, the block raises its interrupt output for one cycle. On the next tick the counter reloads from a separate 16-bit period register and keeps counting, so no cycles are lost between intervals.

Software writes the divider value, the period and the live count through three write strobes, each with its own data port. An enable input gates all counting. The current count is brought out so that software can read it.

Top module: `ival_timer`

## Requirements
- R1: After reset the count, the period and the divider value are zero, and irq_o is low.
- R2: With divider value S, the counter changes once every S+1 enabled cycles. A write to the divider value loads both the divider register and the prescale counter, so the first tick after the write comes S+1 enabled cycles later.
- R3: On a tick, a nonzero count decreases by exactly one.
- R4: On a tick, a count of zero reloads from the period register in that same step. With period P≥1 and divider S, consecutive interrupts are (P+1)*(S+1) enabled cycles apart.
- R5: irq_o is high for exactly one cycle: the first cycle in which count_o reads zero after a step down from one. A count that becomes zero through a write or a reload gives no interrupt, so period 0 gives no interrupts at all.
- R6: While en_i is low, neither the count nor the prescale counter moves and no interrupt is raised. Counting resumes exactly where it stopped.
- R7: A count write takes effect on the next clock edge and takes priority over a tick in that edge. After writing C≥1 with divider S, the interrupt comes C*(S+1) enabled cycles later.
- R8: A period write leaves the current count untouched and is used only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counting enable |
| scale_we_i | input | 1 | Divider value write strobe |
| scale_d_i | input | 8 | Divider value (divides by value+1) |
| period_we_i | input | 1 | Period write strobe |
| period_d_i | input | 16 | Reload period |
| count_we_i | input | 1 | Count write strobe |
| count_d_i | input | 16 | Count write value |
| count_o | output | 16 | Current count |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that the write strobes and data inputs are stable at the clock edge. They also assume that a count write in the same cycle as a tick is meant to win. Beyond that, they allow any mix of strobes together with the enable.

The stimulus drives all inputs half a clock away from the sampling edge and raises at most one strobe per cycle. Most writes are made with the enable low. The writes made while counting avoid the cycle in which a reload happens, so each expected interval follows directly from the divider and period arithmetic.

// File: rtl/ival_timer_pkg.sv
package ival_timer_pkg;
  localparam int unsigned SCALE_W = 8;
  localparam int unsigned COUNT_W = 16;
  typedef logic [SCALE_W-1:0] scale_t;
  typedef logic [COUNT_W-1:0] count_t;
endpackage

// File: rtl/ival_prescaler.sv
module ival_prescaler #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] scale_i,
  output logic         tick_o
);
  logic [W-1:0] pcnt_q;

  assign tick_o = en_i && !load_i && (pcnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pcnt_q <= '0;
    else if (load_i)      pcnt_q <= load_val_i;
    else if (en_i) begin
      if (pcnt_q == '0)   pcnt_q <= scale_i;
      else                pcnt_q <= pcnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ival_downcount.sv
module ival_downcount #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         irq_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= !load_i && tick_i && (cnt_o == ONE);
      if (load_i)               cnt_o <= load_val_i;
      else if (tick_i) begin
        if (cnt_o == '0)        cnt_o <= period_i;
        else                    cnt_o <= cnt_o - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ival_timer.sv
module ival_timer
  import ival_timer_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  logic   scale_we_i,
  input  scale_t scale_d_i,
  input  logic   period_we_i,
  input  count_t period_d_i,
  input  logic   count_we_i,
  input  count_t count_d_i,
  output count_t count_o,
  output logic   irq_o
);
  scale_t scale_q;
  count_t period_q;
  logic   tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scale_q  <= '0;
      period_q <= '0;
    end else begin
      if (scale_we_i)  scale_q  <= scale_d_i;
      if (period_we_i) period_q <= period_d_i;
    end
  end

  ival_prescaler #(.W(SCALE_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .load_i     (scale_we_i),
    .load_val_i (scale_d_i),
    .scale_i    (scale_q),
    .tick_o     (tick)
  );

  ival_downcount #(.W(COUNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (count_we_i),
    .load_val_i (count_d_i),
    .period_i   (period_q),
    .cnt_o      (count_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/ival_timer_chk.sv
module ival_timer_chk
  import ival_timer_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   en_i,
  input logic   count_we_i,
  input count_t count_d_i,
  input count_t count_o,
  input logic   irq_o,
  input logic   tick,
  input count_t period_q
);
  assert_irq_at_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (count_o == '0));

  assert_irq_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !count_we_i) |=> ($stable(count_o) && !irq_o));

  assert_count_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_we_i |=> (count_o == $past(count_d_i)));

  assert_decrement_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !count_we_i && count_o != '0) |=> (count_o == $past(count_o) - 1'b1));

  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !count_we_i && count_o == '0) |=> (count_o == $past(period_q)));
endmodule

bind ival_timer ival_timer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .count_we_i (count_we_i),
  .count_d_i  (count_d_i),
  .count_o    (count_o),
  .irq_o      (irq_o),
  .tick       (tick),
  .period_q   (period_q)
);

// File: tb/ival_timer_bench.sv
module ival_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        scale_we_i = 1'b0;
  logic [7:0]  scale_d_i = '0;
  logic        period_we_i = 1'b0;
  logic [15:0] period_d_i = '0;
  logic        count_we_i = 1'b0;
  logic [15:0] count_d_i = '0;
  logic [15:0] count_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ival_timer u_ival_timer (.*);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic setup(input int s, input int p, input int c);
    en_i = 0;
    scale_d_i = 8'(s); scale_we_i = 1; step(); scale_we_i = 0;
    period_d_i = 16'(p); period_we_i = 1; step(); period_we_i = 0;
    count_d_i = 16'(c); count_we_i = 1; step(); count_we_i = 0;
  endtask

  // returns enabled-cycle index of next irq, -1 on timeout
  task automatic wait_irq(input int limit, inout int n, output int at);
    at = -1;
    while (at < 0 && limit > 0) begin
      step(); n++; limit--;
      if (irq_o) at = n;
    end
  endtask

  task automatic measure(input int s, input int p);
    int n, first, second;
    n = 0;
    setup(s, p, p);
    en_i = 1;
    wait_irq(300000, n, first);
    check("R2 first irq latency", first, p*(s+1));
    wait_irq(300000, n, second);
    check("R4 irq interval", second - first, (p+1)*(s+1));
    en_i = 0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 190000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int n, at, held;
    @(negedge clk_i); @(negedge clk_i);
    check("R1 reset count", count_o, 0);
    check("R1 reset irq", irq_o, 0);
    rst_ni = 1;
    step();
    en_i = 1;
    for (int i = 0; i < 3; i++) step();
    check("R1 count stays zero with period zero", count_o, 0);
    en_i = 0;

    for (int s = 0; s < 8; s++)
      for (int p = 1; p < 7; p++) measure(s, p);
    measure(255, 2);
    measure(0, 300);

    // R5: period 0 never interrupts
    setup(3, 0, 0);
    en_i = 1; held = 0;
    for (int i = 0; i < 60; i++) begin step(); if (irq_o) held++; end
    check("R5 no irq with period zero", held, 0);
    en_i = 0;

    // R6: freeze and resume
    setup(2, 3, 3);
    en_i = 1; n = 0;
    for (int i = 0; i < 5; i++) begin step(); n++; end
    en_i = 0;
    held = count_o; at = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (count_o != 16'(held)) at++;
      if (irq_o) at++;
    end
    check("R6 frozen while disabled", at, 0);
    en_i = 1;
    wait_irq(1000, n, at);
    check("R6 resume latency", at, 9);
    en_i = 0;

    // R8: period write affects only next reload
    setup(0, 4, 4);
    en_i = 1; n = 0;
    step(); n++; step(); n++;
    period_d_i = 16'd9; period_we_i = 1; step(); n++; period_we_i = 0;
    check("R8 count unaffected by period write", count_o, 1);
    wait_irq(100, n, at);
    check("R8 old irq time", at, 4);
    wait_irq(100, n, held);
    check("R8 new period interval", held - at, 10);

    // R7: count write immediate, overrides tick
    step(); n++;
    count_d_i = 16'd2; count_we_i = 1; step(); n++; count_we_i = 0;
    check("R7 count write immediate", count_o, 2);
    at = n;
    wait_irq(100, n, held);
    check("R7 irq after write", held - at, 2);
    en_i = 0;

    // R7 with prescaler
    setup(4, 50, 3);
    en_i = 1; n = 0;
    wait_irq(1000, n, at);
    check("R7 write latency with divider", at, 15);
    step();
    check("R5 pulse one cycle", irq_o, 0);
    en_i = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule